// File: doc/BRIEF.md
# Wired-to-Message Interrupt Generator

The block turns a bank of wired interrupt lines into message-signalled interrupt writes. Each implemented line has a trigger mode, either level-high or rising-edge, and a 22-bit vector word. The vector word packs a 10-bit event identifier above a 12-bit device identifier. When a line fires, the block records a pending status for it. It then sends exactly one message carrying that line's vector word on a valid/ready output port. The line stays quiet until software clears its status.

Software reaches the block through a flat 32-bit register port with a 16-bit byte address. Reads are combinational. A write takes effect on the clock edge where the write enable is high. Pin numbers are absolute, and numbers 0 to 63 are reserved. Implemented pin `p` (p ≥ 64) belongs to node `(p-64)/128 + 1` at in-node index `(p-64) mod 128`. Each node owns a 0x1000-byte window that holds its trigger-type words and its vector words. Status clearing uses one shared region, indexed by absolute pin number. Input bit `irq_i[j]` is absolute pin `j+64`.

When several lines are pending at once, a round-robin arbiter picks the next one to send. The message target address is a build-time constant and cannot be programmed by software. `NUM_NODES` must stay at 9 or below so that node windows never reach the clear region.

Top module: `wmi_gen`

## Requirements
- R1: Pin p has a vector word at byte address node*0x1000 + 0x200 + inpin*4. Bits [21:12] hold the event id and bits [11:0] hold the device id. Written bits [31:22] are dropped and read back as zero. After reset every vector word is zero.
- R2: Pin p's trigger bit sits at node*0x1000 + (inpin/32)*4, bit inpin mod 32. A 1 selects level-high and a 0 selects rising-edge. All trigger bits reset to 0.
- R3: Reads return zero from the node-0 window, from windows above the last implemented node, from offsets in a node window that hold no register, and from the clear region.
- R4: A write to 0xA000 + (p/32)*4 with bit p mod 32 set clears pin p's pending status. A 0 in that bit has no effect on pin p.
- R5: On an edge-type pin, a rising input sets the status. With the output idle, `msg_valid_o` is high after the second rising clock edge that samples the input high, and not after the first.
- R6: A pending pin sends exactly one message and sends no more until its status is cleared. An edge-type pin that sees one or more rising edges while pending sends one further message after the clear, and only one.
- R7: On a level-type pin, a high input sets the status. If the input is still high when the status is cleared, the status is set again and a new message follows.
- R8: `msg_data_o` is {event id, device id} of the granted pin, taken when the message is loaded. It holds steady while `msg_valid_o` is high and `msg_ready_i` is low, even if that vector word is rewritten.
- R9: After the arbiter grants pin index k, the next grant goes to the lowest pending index above k. If no pending index is above k, it wraps to the lowest pending index.
- R10: `msg_addr_o` always equals the `DOORBELL` parameter.
- R11: While and right after reset, `msg_valid_o` is low and no status is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_NODES*128 | Wired interrupt lines; bit j is absolute pin j+64 |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 16 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| msg_valid_o | output | 1 | Message available |
| msg_ready_i | input | 1 | Message accepted when high with msg_valid_o |
| msg_data_o | output | 22 | {event id, device id} of the message |
| msg_addr_o | output | 32 | Fixed message target address |

## Verification
The register map is swept over every pin of a one-node build. Each vector word is written with a distinct arithmetic pattern and with junk in the upper bits, which separates address-decode aliasing from field masking. Every pin is then fired once as an edge source, taken, cleared and watched for a spurious repeat, which confirms that absolute clear indexing matches node-relative vector indexing. Further patterns are checked one at a time: repeated pulses on a pending edge pin, a level pin held high across its clear, a clear word carrying zero in the pin's bit, a vector rewrite under back-pressure, and two groups of simultaneous requests placed around the round-robin pointer. Each pattern separates one of these from the others: recorded edges, level re-fire, ignored zero bits, payload capture and fair rotation.

// File: rtl/wmi_pkg.sv
`timescale 1ns/1ps
package wmi_pkg;
  localparam int unsigned RSV_PINS      = 64;
  localparam int unsigned PINS_PER_NODE = 128;
  localparam int unsigned EVT_W         = 10;
  localparam int unsigned DEV_W         = 12;
  localparam int unsigned MSG_W         = EVT_W + DEV_W;
  localparam logic [15:0] CLR_BASE      = 16'hA000;

  typedef struct packed {
    logic [EVT_W-1:0] evt;
    logic [DEV_W-1:0] dev;
  } vec_t;
endpackage

// File: rtl/wmi_regs.sv
`timescale 1ns/1ps
module wmi_regs import wmi_pkg::*; #(
  parameter int unsigned NUM_PINS = 256
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [15:0]         addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic [NUM_PINS-1:0] lvl_o,
  output vec_t                vec_o [NUM_PINS],
  output logic [NUM_PINS-1:0] clr_o
);
  localparam int unsigned NODES     = NUM_PINS / PINS_PER_NODE;
  localparam int unsigned CLR_WORDS = (RSV_PINS + NUM_PINS + 31) / 32;

  logic [3:0]  node;
  logic [11:0] off;
  logic        is_clr, win_ok, is_typ, is_vec;
  logic [15:0] clr_word;
  logic [31:0] rd_w [NUM_PINS];

  assign node     = addr_i[15:12];
  assign off      = addr_i[11:0];
  assign is_clr   = (addr_i >= CLR_BASE) && (addr_i < 16'(32'(CLR_BASE) + CLR_WORDS*4));
  assign win_ok   = !is_clr && (node != 4'd0) && (32'(node) <= NODES);
  assign is_typ   = win_ok && (off[11:4] == 8'd0);
  assign is_vec   = win_ok && (off[11:9] == 3'b001);
  assign clr_word = (addr_i - CLR_BASE) >> 2;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam int unsigned AP  = i + RSV_PINS;
    localparam int unsigned IP  = i % PINS_PER_NODE;
    localparam logic [3:0]  NID = 4'(i / PINS_PER_NODE + 1);
    logic typ_hit, vec_hit, lvl_q;
    vec_t vec_q;

    assign typ_hit  = is_typ && (node == NID) && (off[3:2] == 2'(IP / 32));
    assign vec_hit  = is_vec && (node == NID) && (off[8:2] == 7'(IP));
    assign clr_o[i] = we_i && is_clr && (clr_word == 16'(AP / 32)) && wdata_i[AP % 32];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_q <= 1'b0;
        vec_q <= '0;
      end else if (we_i) begin
        if (typ_hit) lvl_q <= wdata_i[IP % 32];
        if (vec_hit) vec_q <= vec_t'(wdata_i[MSG_W-1:0]);
      end
    end

    assign lvl_o[i] = lvl_q;
    assign vec_o[i] = vec_q;
    assign rd_w[i]  = typ_hit ? (32'(lvl_q) << (IP % 32)) :
                      vec_hit ? {{(32-MSG_W){1'b0}}, vec_q} : 32'd0;
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_PINS; k++) rdata_o |= rd_w[k];
  end
endmodule

// File: rtl/wmi_pin.sv
`timescale 1ns/1ps
module wmi_pin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic lvl_i,
  input  logic clr_i,
  input  logic take_i,
  output logic req_o
);
  logic irq_q, sts_q, req_q, hold_q;
  logic sts_d, req_d, hold_d, rise, hit;

  assign rise = irq_i & ~irq_q;
  assign hit  = lvl_i ? irq_i : rise;

  always_comb begin
    sts_d  = sts_q;
    req_d  = req_q;
    hold_d = hold_q;
    if (take_i) req_d = 1'b0;
    if (clr_i) begin
      sts_d  = 1'b0;
      req_d  = 1'b0;
      hold_d = 1'b0;
      // edge seen while pending, or on the clear cycle itself, re-arms at once
      if (!lvl_i && (hold_q || rise)) begin
        sts_d = 1'b1;
        req_d = 1'b1;
      end
    end else if (!sts_q && hit) begin
      sts_d = 1'b1;
      req_d = 1'b1;
    end else if (sts_q && !lvl_i && rise) begin
      hold_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      sts_q  <= 1'b0;
      req_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      irq_q  <= irq_i;
      sts_q  <= sts_d;
      req_q  <= req_d;
      hold_q <= hold_d;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/wmi_rr_arb.sv
`timescale 1ns/1ps
module wmi_rr_arb #(
  parameter  int unsigned N  = 256,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] ptr_q, lo_idx, hi_idx;
  logic          lo_v, hi_v;

  always_comb begin
    lo_v   = 1'b0;
    hi_v   = 1'b0;
    lo_idx = '0;
    hi_idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        lo_v   = 1'b1;
        lo_idx = IW'(k);
      end
      if (req_i[k] && (IW'(k) >= ptr_q)) begin
        hi_v   = 1'b1;
        hi_idx = IW'(k);
      end
    end
    vld_o = lo_v;
    idx_o = hi_v ? hi_idx : lo_idx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ptr_q <= '0;
    else if (adv_i && vld_o)  ptr_q <= idx_o + 1'b1;
  end
endmodule

// File: rtl/wmi_gen.sv
`timescale 1ns/1ps
module wmi_gen import wmi_pkg::*; #(
  parameter  int unsigned NUM_NODES = 2,
  parameter  logic [31:0] DOORBELL  = 32'h0004_0040,
  localparam int unsigned NUM_PINS  = NUM_NODES * PINS_PER_NODE,
  localparam int unsigned IW        = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] irq_i,
  input  logic                reg_we_i,
  input  logic [15:0]         reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [MSG_W-1:0]    msg_data_o,
  output logic [31:0]         msg_addr_o
);
  logic [NUM_PINS-1:0] lvl, clr, req, take;
  vec_t                vec [NUM_PINS];
  logic                arb_vld, load, valid_q;
  logic [IW-1:0]       arb_idx;
  vec_t                data_q;

  wmi_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .lvl_o(lvl), .vec_o(vec), .clr_o(clr)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign take[i] = load && (arb_idx == IW'(i));
    wmi_pin u_pin (
      .clk_i, .rst_ni,
      .irq_i(irq_i[i]), .lvl_i(lvl[i]), .clr_i(clr[i]), .take_i(take[i]), .req_o(req[i])
    );
  end

  wmi_rr_arb #(.N(NUM_PINS)) u_arb (
    .clk_i, .rst_ni, .req_i(req), .adv_i(load), .vld_o(arb_vld), .idx_o(arb_idx)
  );

  assign load = arb_vld && (!valid_q || msg_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      data_q  <= vec[arb_idx];
    end else if (msg_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign msg_valid_o = valid_q;
  assign msg_data_o  = data_q;
  assign msg_addr_o  = DOORBELL;
endmodule

// File: rtl/wmi_gen_chk.sv
`timescale 1ns/1ps
module wmi_gen_chk #(
  parameter int unsigned NUM_PINS = 256,
  parameter int unsigned MSG_W    = 22
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] req_i,
  input logic [NUM_PINS-1:0] take_i,
  input logic                msg_valid_o,
  input logic                msg_ready_i,
  input logic [MSG_W-1:0]    msg_data_o,
  input logic [15:0]         reg_addr_i,
  input logic [31:0]         reg_rdata_o
);
  assert_payload_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_data_o)));

  assert_msg_from_pending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) |-> $past(|req_i));

  assert_grant_is_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((take_i & ~req_i) == '0) && $onehot0(take_i));

  assert_node0_reads_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i[15:12] == 4'd0) |-> (reg_rdata_o == 32'd0));
endmodule

bind wmi_gen wmi_gen_chk #(.NUM_PINS(NUM_PINS), .MSG_W(wmi_pkg::MSG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .take_i(take),
  .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i), .msg_data_o(msg_data_o),
  .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o)
);

// File: tb/wmi_gen_tb_top.sv
`timescale 1ns/1ps
module wmi_gen_tb_top;
  localparam int unsigned NODES = 1;
  localparam int unsigned NP    = 128;
  localparam logic [31:0] DB    = 32'h0A0B_0C40;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NP-1:0] irq = '0;
  logic          we = 1'b0, mr = 1'b0, mv;
  logic [15:0]   addr = '0;
  logic [31:0]   wdata = '0, rdata, ma;
  logic [21:0]   md;
  int            n_run = 0, n_fail = 0;
  bit            done = 1'b0;

  wmi_gen #(.NUM_NODES(NODES), .DOORBELL(DB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .msg_valid_o(mv), .msg_ready_i(mr), .msg_data_o(md), .msg_addr_o(ma)
  );

  task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [21:0] vexp(int i);
    return {10'((i * 37 + 11) % 1024), 12'((i * 291 + 7) % 4096)};
  endfunction
  function automatic logic [15:0] vaddr(int i);
    return 16'(4096 * (i / 128 + 1) + 512 + (i % 128) * 4);
  endfunction
  function automatic logic [15:0] taddr(int w);
    return 16'(4096 + w * 4);
  endfunction
  function automatic logic [15:0] caddr(int i);
    return 16'(40960 + ((i + 64) / 32) * 4);
  endfunction
  function automatic logic [31:0] cbit(int i);
    return 32'(1) << ((i + 64) % 32);
  endfunction

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask
  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask
  task automatic clear(int i);
    wr(caddr(i), cbit(i));
  endtask
  task automatic take_msg(logic [21:0] exp, string rq);
    int w = 0;
    while (!mv && w < 20) begin @(negedge clk); w++; end
    chk(mv, rq, "message valid", 32'(mv), 32'd1);
    chk(md == exp, rq, "message data", 32'(md), 32'(exp));
    mr = 1'b1;
    @(negedge clk); mr = 1'b0;
  endtask
  task automatic expect_none(int n, string rq);
    bit seen = 1'b0;
    repeat (n) begin @(negedge clk); if (mv) seen = 1'b1; end
    chk(!seen, rq, "no message", 32'(seen), 32'd0);
  endtask
  task automatic pulse(int i);
    @(negedge clk); irq[i] = 1'b0;
    @(negedge clk); irq[i] = 1'b1;
  endtask
  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [21:0] held;
    repeat (3) @(negedge clk);
    chk(!mv, "R11", "valid in reset", 32'(mv), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mv, "R11", "valid after reset", 32'(mv), 32'd0);
    chk(ma == DB, "R10", "doorbell", ma, DB);
    rd(taddr(0), d); chk(d == 0, "R2", "type reset", d, 0);
    rd(vaddr(0), d); chk(d == 0, "R1", "vector reset", d, 0);

    // R1: vector map sweep, junk in upper bits
    for (int i = 0; i < NP; i++) wr(vaddr(i), 32'hFFC0_0000 | 32'(vexp(i)));
    for (int i = 0; i < NP; i++) begin
      rd(vaddr(i), d); chk(d == 32'(vexp(i)), "R1", "vector readback", d, 32'(vexp(i)));
    end

    // R3: holes read zero
    rd(16'h0200, d); chk(d == 0, "R3", "node0 vector", d, 0);
    rd(16'h0000, d); chk(d == 0, "R3", "node0 type", d, 0);
    rd(16'h2200, d); chk(d == 0, "R3", "absent node", d, 0);
    rd(16'h1100, d); chk(d == 0, "R3", "unmapped offset", d, 0);
    rd(16'hA008, d); chk(d == 0, "R3", "clear region", d, 0);

    // R2: type word readback
    for (int w = 0; w < 4; w++) wr(taddr(w), 32'hA5A5_0F0F ^ (32'h1111_1111 * 32'(w)));
    for (int w = 0; w < 4; w++) begin
      rd(taddr(w), d);
      chk(d == (32'hA5A5_0F0F ^ (32'h1111_1111 * 32'(w))), "R2", "type readback", d,
          32'hA5A5_0F0F ^ (32'h1111_1111 * 32'(w)));
    end
    for (int w = 0; w < 4; w++) wr(taddr(w), 32'd0);

    // R5: exact latency on pin 0
    @(negedge clk); irq[0] = 1'b1;
    @(negedge clk); chk(!mv, "R5", "valid after first edge", 32'(mv), 32'd0);
    @(negedge clk); chk(mv, "R5", "valid after second edge", 32'(mv), 32'd1);
    take_msg(vexp(0), "R5");
    clear(0);
    irq[0] = 1'b0;

    // R4/R5: every pin once as edge source
    for (int i = 1; i < NP; i++) begin
      @(negedge clk); irq[i] = 1'b1;
      take_msg(vexp(i), "R5");
      clear(i);
      expect_none(3, "R4");
      irq[i] = 1'b0;
    end

    // R6: repeated edges while pending collapse to one
    @(negedge clk); irq[5] = 1'b1;
    take_msg(vexp(5), "R6");
    expect_none(4, "R6");
    pulse(5);
    pulse(5);
    expect_none(5, "R6");
    clear(5);
    take_msg(vexp(5), "R6");
    expect_none(5, "R6");
    clear(5);
    irq[5] = 1'b0;

    // R4: zero in the pin's clear bit is ignored
    @(negedge clk); irq[20] = 1'b1;
    take_msg(vexp(20), "R4");
    pulse(20);
    wr(caddr(20), ~cbit(20));
    expect_none(5, "R4");
    clear(20);
    take_msg(vexp(20), "R4");
    clear(20);
    irq[20] = 1'b0;

    // R7: level pin held high across clear
    wr(taddr(0), 32'(1) << 10);
    @(negedge clk); irq[10] = 1'b1;
    take_msg(vexp(10), "R7");
    expect_none(4, "R7");
    clear(10);
    take_msg(vexp(10), "R7");
    irq[10] = 1'b0;
    clear(10);
    expect_none(4, "R7");
    wr(taddr(0), 32'd0);

    // R8: payload held under back-pressure despite rewrite
    @(negedge clk); irq[30] = 1'b1;
    repeat (3) @(negedge clk);
    held = md;
    chk(mv && held == vexp(30), "R8", "loaded payload", 32'(held), 32'(vexp(30)));
    wr(vaddr(30), 32'h0003_3333);
    repeat (4) @(negedge clk);
    chk(mv && md == held, "R8", "payload stable", 32'(md), 32'(held));
    take_msg(held, "R8");
    clear(30);
    irq[30] = 1'b0;
    wr(vaddr(30), 32'(vexp(30)));

    // R9: round robin order, pointer set to 0 via pin 127
    @(negedge clk); irq[127] = 1'b1;
    take_msg(vexp(127), "R9");
    clear(127);
    irq[127] = 1'b0;
    @(negedge clk); irq[3] = 1'b1; irq[50] = 1'b1; irq[100] = 1'b1;
    take_msg(vexp(3), "R9");
    take_msg(vexp(50), "R9");
    take_msg(vexp(100), "R9");
    clear(3); clear(50); clear(100);
    irq[3] = 1'b0; irq[50] = 1'b0; irq[100] = 1'b0;
    @(negedge clk); irq[10] = 1'b1; irq[120] = 1'b1;
    take_msg(vexp(120), "R9");
    take_msg(vexp(10), "R9");
    clear(10); clear(120);
    irq[10] = 1'b0; irq[120] = 1'b0;
    expect_none(4, "R9");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule